// File: doc/BRIEF.md
# PWM Output Steering Unit

The unit takes a single pulse-width-modulated waveform and routes it to any subset of four output pins. A pin whose steering bit is clear shows the matching bit of a general-purpose port data input, and a pin whose steering bit is set shows the PWM waveform. A small built-in period counter with a programmable period and duty produces the waveform and a one-cycle start-of-period strobe, so the unit can be exercised on its own.

A simple write-only register interface sets up the unit. The steering register holds a four-bit mask and a timing-mode bit that is taken with each write. A write in immediate mode changes the pins in the next cycle, even when that cuts a pulse short. A write in deferred mode is held in a shadow register and applied only when the next period begins, so a pin always carries whole pulses. Period and duty writes are also deferred to the period boundary.

Register map (address on `regAddr`): 0 = steering (bits 3:0 mask, bit 0 for pin 0 through bit 3 for pin 3; bit 4 = timing mode, 0 immediate, 1 deferred), 1 = period, 2 = duty, 3 = unused.

Top module: `pwm_steer_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, every pin shows its port data bit, the counter is at 0 with period 7 and duty 3, so `pwmOut` is 1 and `periodStart` is 1.
- R2: Pin i shows `pwmOut` when bit i of the active mask is 1 and `portData[i]` when it is 0.
- R3: A write to address 0 with bit 4 at 0 makes bits 3:0 the active mask from the cycle after the write.
- R4: A write to address 0 with bit 4 at 1 leaves the active mask unchanged until the next period start; only the last such write before that boundary is applied.
- R5: With deferred writes and port data at 0, every high pulse on any pin lasts exactly duty cycles.
- R6: The counter runs from 0 to the period value and wraps to 0; `periodStart` is 1 exactly in the cycles where the count is 0.
- R7: `pwmOut` is 1 while the count is below the duty value: never high for duty 0, always high for a duty above the period.
- R8: Writes to address 1 (period) and address 2 (duty) take effect only at the next period start.
- R9: A write to address 3 changes no output and no later behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | CNT_W | Register write data |
| portData | input | 4 | Port data shown on unsteered pins |
| pinOut | output | 4 | Steered output pins |
| pwmOut | output | 1 | Generated PWM waveform |
| periodStart | output | 1 | High in the first cycle of each period |

## Verification
All sixteen masks are written in immediate mode with a changing port data pattern, which separates the per-pin multiplexer from the mask timing; the same sixteen masks are then written in deferred mode, some preceded by a different write in the same period, which distinguishes a boundary load from an immediate load and the last write from an earlier one, while every pulse length is measured. A sweep of every period from 1 to 6 with every duty from 0 to one above the period checks the counter wrap, the duty compare at its extremes and the boundary load of timing values. Writes to the unused address and steering writes landing exactly on a boundary cycle close the corner cases.

// File: rtl/pwm_steer_pkg.sv
`timescale 1ns/1ps
package pwm_steer_pkg;
  localparam int NUM_PINS = 4;
  localparam int MODE_BIT = 4;

  typedef enum logic [1:0] {
    ADDR_STEER  = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_DUTY   = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                applyNow;
    logic                applyAtStart;
    logic [NUM_PINS-1:0] maskVal;
  } steerCmd_t;
endpackage

// File: rtl/pwm_steer_ctrl.sv
`timescale 1ns/1ps
module pwm_steer_ctrl
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DEF_PERIOD = 7,
  parameter int DEF_DUTY   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  input  logic             lastCycle,
  output steerCmd_t        cmd,
  output logic [CNT_W-1:0] nextPeriod,
  output logic [CNT_W-1:0] nextDuty
);
  logic [NUM_PINS-1:0] shadowMask;
  logic [CNT_W-1:0]    shadowPeriod;
  logic [CNT_W-1:0]    shadowDuty;
  logic                wrSteer, wrPeriod, wrDuty;

  always_comb begin
    wrSteer  = regWrEn && (regAddr_e'(regAddr) == ADDR_STEER);
    wrPeriod = regWrEn && (regAddr_e'(regAddr) == ADDR_PERIOD);
    wrDuty   = regWrEn && (regAddr_e'(regAddr) == ADDR_DUTY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowMask   <= '0;
      shadowPeriod <= CNT_W'(DEF_PERIOD);
      shadowDuty   <= CNT_W'(DEF_DUTY);
    end else begin
      if (wrSteer)  shadowMask   <= regWrData[NUM_PINS-1:0];
      if (wrPeriod) shadowPeriod <= regWrData;
      if (wrDuty)   shadowDuty   <= regWrData;
    end
  end

  // A write landing on the boundary cycle is forwarded so the last write wins
  always_comb begin
    cmd.applyNow     = wrSteer && !regWrData[MODE_BIT];
    cmd.applyAtStart = lastCycle;
    cmd.maskVal      = wrSteer ? regWrData[NUM_PINS-1:0] : shadowMask;
    nextPeriod       = wrPeriod ? regWrData : shadowPeriod;
    nextDuty         = wrDuty ? regWrData : shadowDuty;
  end

  assert_spare_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr_e'(regAddr) == ADDR_SPARE) |=>
      ($stable(shadowMask) && $stable(shadowPeriod) && $stable(shadowDuty)));
endmodule

// File: rtl/pwm_steer_timer.sv
`timescale 1ns/1ps
module pwm_steer_timer #(
  parameter int CNT_W      = 8,
  parameter int DEF_PERIOD = 7,
  parameter int DEF_DUTY   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] nextPeriod,
  input  logic [CNT_W-1:0] nextDuty,
  output logic             lastCycle,
  output logic             periodStart,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activePeriod;
  logic [CNT_W-1:0] activeDuty;

  always_comb begin
    lastCycle   = (cnt == activePeriod);
    periodStart = (cnt == '0);
    pwmOut      = (cnt < activeDuty);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt          <= '0;
      activePeriod <= CNT_W'(DEF_PERIOD);
      activeDuty   <= CNT_W'(DEF_DUTY);
    end else if (lastCycle) begin
      cnt          <= '0;
      activePeriod <= nextPeriod;
      activeDuty   <= nextDuty;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    lastCycle |=> periodStart);

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= activePeriod);

  assert_timing_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |-> ($stable(activeDuty) && $stable(activePeriod)));

  assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (activeDuty > activePeriod) |-> pwmOut);
endmodule

// File: rtl/pwm_steer_dp.sv
`timescale 1ns/1ps
module pwm_steer_dp
  import pwm_steer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  steerCmd_t           cmd,
  input  logic                pwmIn,
  input  logic                periodStart,
  input  logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] pinOut
);
  logic [NUM_PINS-1:0] activeMask;

  always_ff @(posedge clk) begin
    if (!rstN) activeMask <= '0;
    else if (cmd.applyNow || cmd.applyAtStart) activeMask <= cmd.maskVal;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pinOut[i] = activeMask[i] ? pwmIn : portData[i];
  end

  assert_apply_now_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.applyNow |=> (activeMask == $past(cmd.maskVal)));

  assert_mask_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.applyNow && !cmd.applyAtStart) |=> $stable(activeMask));

  assert_whole_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeMask) && !$past(cmd.applyNow)) |-> periodStart);
endmodule

// File: rtl/pwm_steer_unit.sv
`timescale 1ns/1ps
module pwm_steer_unit
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DEF_PERIOD = 7,
  parameter int DEF_DUTY   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [CNT_W-1:0]    regWrData,
  input  logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                pwmOut,
  output logic                periodStart
);
  steerCmd_t        cmd;
  logic [CNT_W-1:0] nextPeriod;
  logic [CNT_W-1:0] nextDuty;
  logic             lastCycle;

  pwm_steer_ctrl #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_DUTY(DEF_DUTY)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lastCycle(lastCycle), .cmd(cmd),
    .nextPeriod(nextPeriod), .nextDuty(nextDuty)
  );

  pwm_steer_timer #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_DUTY(DEF_DUTY)) timer_i (
    .clk(clk), .rstN(rstN), .nextPeriod(nextPeriod), .nextDuty(nextDuty),
    .lastCycle(lastCycle), .periodStart(periodStart), .pwmOut(pwmOut)
  );

  pwm_steer_dp dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pwmIn(pwmOut),
    .periodStart(periodStart), .portData(portData), .pinOut(pinOut)
  );
endmodule

// File: tb/pwm_steer_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_steer_unit_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [1:0]       regAddr = 2'd0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [3:0]       portData = 4'd0;
  logic [3:0]       pinOut;
  logic             pwmOut;
  logic             periodStart;

  always #4 clk = ~clk;

  pwm_steer_unit #(.CNT_W(CNT_W), .DEF_PERIOD(7), .DEF_DUTY(3)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .portData(portData), .pinOut(pinOut),
    .pwmOut(pwmOut), .periodStart(periodStart)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R2";

  // Reference model state
  int mCnt = 0, mPer = 7, mDuty = 3, mShPer = 7, mShDuty = 3;
  logic [3:0] mAct = 4'd0, mSh = 4'd0;
  bit measure = 1'b0;
  int runLen [4];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit wrS, wrP, wrD, last;
    logic [3:0] d4;
    wrS = regWrEn && regAddr == 2'd0;
    wrP = regWrEn && regAddr == 2'd1;
    wrD = regWrEn && regAddr == 2'd2;
    last = (mCnt == mPer);
    d4 = regWrData[3:0];
    if (last) begin
      mAct  = wrS ? d4 : mSh;
      mPer  = wrP ? int'(regWrData) : mShPer;
      mDuty = wrD ? int'(regWrData) : mShDuty;
      mCnt  = 0;
    end else begin
      mCnt++;
    end
    if (wrS && !regWrData[4]) mAct = d4;
    if (wrS) mSh = d4;
    if (wrP) mShPer = int'(regWrData);
    if (wrD) mShDuty = int'(regWrData);
  endtask

  task automatic compareAll();
    logic expPwm;
    logic [3:0] expPins;
    expPwm = (mCnt < mDuty);
    for (int i = 0; i < 4; i++) expPins[i] = mAct[i] ? expPwm : portData[i];
    check(tag, int'(pinOut), int'(expPins));
    check("R7", int'(pwmOut), int'(expPwm));
    check("R6", int'(periodStart), int'(mCnt == 0));
    if (measure) begin
      for (int i = 0; i < 4; i++) begin
        if (pinOut[i]) runLen[i]++;
        else if (runLen[i] > 0) begin
          check("R5", runLen[i], mDuty);
          runLen[i] = 0;
        end
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic wr(input int addr, input int data);
    regWrEn = 1'b1;
    regAddr = 2'(addr);
    regWrData = CNT_W'(data);
    cycle();
    regWrEn = 1'b0;
  endtask

  task automatic waitLast();
    while (mCnt != mPer) cycle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    portData = 4'b1010;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", int'(pinOut), 4'b1010);
    check("R1", int'(pwmOut), 1);
    check("R1", int'(periodStart), 1);
    rstN = 1'b1;
    run(9);

    // R2 R3: immediate mode, every mask, changing port data
    tag = "R2 R3";
    for (int m = 0; m < 16; m++) begin
      portData = 4'((m * 5 + 3) & 15);
      wr(0, m);
      portData = 4'((m * 7 + 9) & 15);
      run((m % 5) + 2);
    end

    // R4 R5: deferred mode, last write wins, whole pulses
    tag = "R4 R5";
    portData = 4'd0;
    wr(0, 0);
    waitLast();
    for (int i = 0; i < 4; i++) runLen[i] = 0;
    measure = 1'b1;
    for (int m = 0; m < 16; m++) begin
      run(2);
      if (m % 2 == 1) wr(0, 16 | ((m + 5) & 15));
      wr(0, 16 | m);
      run(1);
      waitLast();
      run(mPer + 1);
    end
    // deferred write landing exactly on the boundary cycle
    waitLast();
    wr(0, 16 | 4'b0110);
    run(mPer + 2);
    waitLast();
    measure = 1'b0;

    // R6 R7 R8: sweep period and duty, all pins steered
    tag = "R8";
    wr(0, 4'hF);
    for (int p = 1; p <= 6; p++) begin
      for (int d = 0; d <= p + 1; d++) begin
        run(1);
        wr(1, p);
        wr(2, d);
        waitLast();
        run(2 * (p + 1) + 1);
      end
    end

    // R9: unused address write has no effect
    tag = "R9";
    wr(1, 5);
    wr(2, 2);
    waitLast();
    run(3);
    portData = 4'b0101;
    wr(3, 8'h10);
    wr(3, 8'hFF);
    run(20);
    wr(3, 0);
    waitLast();
    run(8);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule